// File: doc/BRIEF.md
# Packed Q15 Halfword Adder

This execute-stage unit handles one instruction of a 32-bit DSP extension: an element-wise add of two signed Q15 halfword pairs. It decodes the instruction word, names the two source registers to the register file, takes the two 32-bit operands that come back, and adds the upper and lower halfwords as two independent lanes. One instruction bit selects between a wrapping add and a saturating add.

One cycle after a valid strobe, the unit presents the 32-bit result with its destination index and a write enable. At the same edge it updates its own 32-bit DSP control register. Bit 20 of that register is a sticky overflow flag, set whenever either lane overflows in either mode. Software can load the whole control register through a separate write port, and that write wins over the sticky set when both happen in the same cycle.

The unit does not write back words it does not recognise. It flags them as reserved instructions. When the DSP resource is disabled, it flags that instead and leaves the register file and the control register untouched.

Top module: `q15_pair_add_unit`

## Requirements
- R1: The instruction word fields, from the MSB, are: major opcode [31:26] = 6'b001000, rt index [25:21], rs index [20:16], rd index [15:11], saturate select [10], sub-opcode [9:3] = 7'b0000001, minor opcode [2:0] = 3'b101. The outputs `rs_idx_o` and `rt_idx_o` follow bits [20:16] and [25:21] combinationally.
- R2: Result bits [31:16] depend only on the upper halfwords of rs and rt, and result bits [15:0] depend only on the lower halfwords. There is no carry or other interaction between the lanes.
- R3: With the saturate select at 0, each lane returns the low 16 bits of the signed 17-bit sum, so an overflow wraps modulo 2^16.
- R4: With the saturate select at 1, a lane that overflows positively returns 16'h7FFF and a lane that overflows negatively returns 16'h8000. A lane that does not overflow returns the same value as in wrap mode.
- R5: An executed instruction in either mode sets control bit 20 if either lane overflows. The bit stays set until a software write clears it. An instruction never clears it.
- R6: An instruction leaves every control register bit other than bit 20 unchanged.
- R7: When `ctrl_wr_i` is high at a clock edge, the control register loads `ctrl_wdata_i` in full. This takes priority over a sticky set in the same cycle.
- R8: A valid word whose major opcode, sub-opcode or minor opcode differs from R1 produces a one-cycle `rsvd_instr_o` pulse. It causes no write enable and no flag update. This fault takes precedence over the disabled fault.
- R9: A valid, recognised word with `dsp_enable_i` low produces a one-cycle `dsp_disabled_o` pulse. It causes no write enable and no flag update.
- R10: `rd_wen_o`, `rd_idx_o` and `rd_data_o` appear exactly one cycle after the valid strobe. The write enable, `rsvd_instr_o` and `dsp_disabled_o` are single-cycle pulses, and at most one of the three is high in any cycle.
- R11: While `rst_ni` is low, every output pulse is 0, the result and index are 0, and the control register holds 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction strobe |
| instr_i | input | 32 | Instruction word |
| dsp_enable_i | input | 1 | DSP resource enabled |
| rs_data_i | input | 32 | rs operand from the register file |
| rt_data_i | input | 32 | rt operand from the register file |
| ctrl_wr_i | input | 1 | Software write to the control register |
| ctrl_wdata_i | input | 32 | Software write data |
| rs_idx_o | output | 5 | rs read index |
| rt_idx_o | output | 5 | rt read index |
| rd_wen_o | output | 1 | Destination write enable |
| rd_idx_o | output | 5 | Destination index |
| rd_data_o | output | 32 | Result of the packed add |
| rsvd_instr_o | output | 1 | Reserved-instruction fault pulse |
| dsp_disabled_o | output | 1 | DSP-disabled fault pulse |
| dsp_ctrl_o | output | 32 | DSP control register |

## Verification
The hardest case to reach is a software control write that lands in the same cycle as an overflowing instruction. Both want bit 20, and only the priority rule decides the result. The stimulus first lets the flag become set, then issues an overflowing add in the same cycle as a write that clears bit 20. It also covers the opposite order, so that the sticky set and the clear are each seen winning where they should. Fault words are built from overflowing operands after the flag has been cleared, so any wrongly allowed flag update or write-back shows up at the ports.

// File: rtl/q15_add_pkg.sv
package q15_add_pkg;
  localparam int unsigned INSTR_W   = 32;
  localparam int unsigned LANE_W    = 16;
  localparam int unsigned LANES     = 2;
  localparam int unsigned DATA_W    = LANE_W * LANES;
  localparam int unsigned REG_IDX_W = 5;
  localparam int unsigned CTRL_W    = 32;

  localparam logic [5:0] MAJOR_OP = 6'b001000;
  localparam logic [6:0] SUB_OP   = 7'b0000001;
  localparam logic [2:0] MINOR_OP = 3'b101;

  typedef struct packed {
    logic [5:0]           major;
    logic [REG_IDX_W-1:0] rt;
    logic [REG_IDX_W-1:0] rs;
    logic [REG_IDX_W-1:0] rd;
    logic                 sat;
    logic [6:0]           sub;
    logic [2:0]           minor;
  } instr_fields_t;

  typedef enum logic [1:0] {
    OUT_NONE,
    OUT_WRITE,
    OUT_RSVD,
    OUT_DISABLED
  } outcome_e;
endpackage

// File: rtl/q15_add_decode.sv
module q15_add_decode
  import q15_add_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output instr_fields_t      fields_o,
  output logic               match_o
);
  always_comb begin
    fields_o = instr_fields_t'(instr_i);
    match_o  = (fields_o.major == MAJOR_OP) &&
               (fields_o.sub   == SUB_OP)   &&
               (fields_o.minor == MINOR_OP);
  end
endmodule

// File: rtl/q15_sat_lane.sv
module q15_sat_lane #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sat_i,
  output logic [W-1:0] res_o,
  output logic         ovf_o
);
  localparam logic [W-1:0] POS_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_MIN = {1'b1, {(W-1){1'b0}}};

  logic [W:0] sum;

  always_comb begin
    sum   = {a_i[W-1], a_i} + {b_i[W-1], b_i};
    ovf_o = sum[W] ^ sum[W-1];
    if (ovf_o && sat_i) res_o = sum[W] ? NEG_MIN : POS_MAX;
    else                res_o = sum[W-1:0];
  end
endmodule

// File: rtl/q15_dsp_ctrl_reg.sv
module q15_dsp_ctrl_reg #(
  parameter int unsigned          CTRL_W  = 32,
  parameter int unsigned          OVF_BIT = 20,
  parameter logic [CTRL_W-1:0]    RST_VAL = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [CTRL_W-1:0] wdata_i,
  input  logic              ovf_set_i,
  output logic [CTRL_W-1:0] ctrl_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ctrl_o <= RST_VAL;
    else if (wr_i)      ctrl_o <= wdata_i;     // software write wins
    else if (ovf_set_i) ctrl_o[OVF_BIT] <= 1'b1;
  end
endmodule

// File: rtl/q15_pair_add_unit.sv
module q15_pair_add_unit
  import q15_add_pkg::*;
#(
  parameter int unsigned       OVF_BIT  = 20,
  parameter logic [CTRL_W-1:0] CTRL_RST = '0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic [INSTR_W-1:0]   instr_i,
  input  logic                 dsp_enable_i,
  input  logic [DATA_W-1:0]    rs_data_i,
  input  logic [DATA_W-1:0]    rt_data_i,
  input  logic                 ctrl_wr_i,
  input  logic [CTRL_W-1:0]    ctrl_wdata_i,
  output logic [REG_IDX_W-1:0] rs_idx_o,
  output logic [REG_IDX_W-1:0] rt_idx_o,
  output logic                 rd_wen_o,
  output logic [REG_IDX_W-1:0] rd_idx_o,
  output logic [DATA_W-1:0]    rd_data_o,
  output logic                 rsvd_instr_o,
  output logic                 dsp_disabled_o,
  output logic [CTRL_W-1:0]    dsp_ctrl_o
);
  instr_fields_t     fields;
  logic              match;
  logic [DATA_W-1:0] sum_d;
  logic [LANES-1:0]  lane_ovf;
  outcome_e          outcome;
  logic              ovf_set;

  q15_add_decode u_dec (
    .instr_i  (instr_i),
    .fields_o (fields),
    .match_o  (match)
  );

  assign rs_idx_o = fields.rs;
  assign rt_idx_o = fields.rt;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    q15_sat_lane #(.W(LANE_W)) u_lane (
      .a_i   (rs_data_i[g*LANE_W +: LANE_W]),
      .b_i   (rt_data_i[g*LANE_W +: LANE_W]),
      .sat_i (fields.sat),
      .res_o (sum_d[g*LANE_W +: LANE_W]),
      .ovf_o (lane_ovf[g])
    );
  end

  always_comb begin
    if (!valid_i)           outcome = OUT_NONE;
    else if (!match)        outcome = OUT_RSVD;
    else if (!dsp_enable_i) outcome = OUT_DISABLED;
    else                    outcome = OUT_WRITE;
  end

  assign ovf_set = (outcome == OUT_WRITE) && (|lane_ovf);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_wen_o       <= 1'b0;
      rsvd_instr_o   <= 1'b0;
      dsp_disabled_o <= 1'b0;
    end else begin
      rd_wen_o       <= (outcome == OUT_WRITE);
      rsvd_instr_o   <= (outcome == OUT_RSVD);
      dsp_disabled_o <= (outcome == OUT_DISABLED);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_idx_o  <= '0;
      rd_data_o <= '0;
    end else if (outcome == OUT_WRITE) begin
      rd_idx_o  <= fields.rd;
      rd_data_o <= sum_d;
    end
  end

  q15_dsp_ctrl_reg #(
    .CTRL_W  (CTRL_W),
    .OVF_BIT (OVF_BIT),
    .RST_VAL (CTRL_RST)
  ) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (ctrl_wr_i),
    .wdata_i   (ctrl_wdata_i),
    .ovf_set_i (ovf_set),
    .ctrl_o    (dsp_ctrl_o)
  );
endmodule

// File: rtl/q15_pair_add_chk.sv
module q15_pair_add_chk
  import q15_add_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 valid_i,
  input logic [INSTR_W-1:0]   instr_i,
  input logic                 dsp_enable_i,
  input logic                 ctrl_wr_i,
  input logic [CTRL_W-1:0]    ctrl_wdata_i,
  input logic                 rd_wen_o,
  input logic                 rsvd_instr_o,
  input logic                 dsp_disabled_o,
  input logic [CTRL_W-1:0]    dsp_ctrl_o
);
  localparam int unsigned FLAG = 20;
  localparam logic [CTRL_W-1:0] KEEP = ~(CTRL_W'(1) << FLAG);

  AST_ONE_OUTCOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rd_wen_o, rsvd_instr_o, dsp_disabled_o})); // R10
  AST_WEN_AFTER_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_wen_o |-> $past(valid_i) && $past(dsp_enable_i)); // R10
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dsp_ctrl_o[FLAG] && !ctrl_wr_i) |=> dsp_ctrl_o[FLAG]); // R5
  AST_OTHER_BITS_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_wr_i |=> ((dsp_ctrl_o & KEEP) == ($past(dsp_ctrl_o) & KEEP))); // R6
  AST_SW_WRITE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr_i |=> (dsp_ctrl_o == $past(ctrl_wdata_i))); // R7
  AST_RSVD_AFTER_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsvd_instr_o |-> $past(valid_i) && ($past(instr_i[31:26]) != MAJOR_OP
      || $past(instr_i[9:3]) != SUB_OP || $past(instr_i[2:0]) != MINOR_OP)); // R8
  AST_FAULT_NO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rsvd_instr_o || dsp_disabled_o) && !$past(ctrl_wr_i))
      |-> $stable(dsp_ctrl_o)); // R9
  AST_DISABLED_NEEDS_LOW_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dsp_disabled_o |-> !$past(dsp_enable_i)); // R9
endmodule

bind q15_pair_add_unit q15_pair_add_chk chk_i (.*);

// File: tb/q15_pair_add_unit_tb_top.sv
module q15_pair_add_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [31:0] instr = '0;
  logic        en = 1'b1;
  logic [31:0] rs_d = '0, rt_d = '0;
  logic        cwr = 1'b0;
  logic [31:0] cwd = '0;
  logic [4:0]  rs_idx, rt_idx, rd_idx;
  logic        wen, rsvd, dis;
  logic [31:0] rd_data, ctrl;

  int checks = 0;
  int errors = 0;
  logic [31:0] ctrl_model = '0;
  logic [31:0] seed = 32'h1357_9bdf;

  typedef struct {
    logic        wen;
    logic [4:0]  idx;
    logic [31:0] data;
    logic        rsvd;
    logic        dis;
    logic [31:0] ctrl;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  always #5 clk = ~clk;

  q15_pair_add_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .instr_i(instr),
    .dsp_enable_i(en), .rs_data_i(rs_d), .rt_data_i(rt_d),
    .ctrl_wr_i(cwr), .ctrl_wdata_i(cwd),
    .rs_idx_o(rs_idx), .rt_idx_o(rt_idx), .rd_wen_o(wen), .rd_idx_o(rd_idx),
    .rd_data_o(rd_data), .rsvd_instr_o(rsvd), .dsp_disabled_o(dis),
    .dsp_ctrl_o(ctrl)
  );

  function automatic logic [31:0] enc(input logic [4:0] rt, rs, rd, input logic s);
    return {6'b001000, rt, rs, rd, s, 7'b0000001, 3'b101};
  endfunction

  // {overflow, result}
  function automatic logic [16:0] ref_lane(input logic [15:0] a, b, input logic s);
    int v;
    v = int'($signed(a)) + int'($signed(b));
    if (v > 32767)  return {1'b1, s ? 16'h7FFF : 16'(v)};
    if (v < -32768) return {1'b1, s ? 16'h8000 : 16'(v)};
    return {1'b0, 16'(v)};
  endfunction

  task automatic step(input logic v, input logic [31:0] iw, a, b,
                      input logic e, input logic w, input logic [31:0] wd,
                      input string tag);
    exp_t x;
    logic [16:0] hi, lo;
    logic known;
    @(negedge clk);
    valid = v; instr = iw; rs_d = a; rt_d = b; en = e; cwr = w; cwd = wd;
    known = (iw[31:26] == 6'b001000) && (iw[9:3] == 7'b0000001) && (iw[2:0] == 3'b101);
    hi = ref_lane(a[31:16], b[31:16], iw[10]);
    lo = ref_lane(a[15:0], b[15:0], iw[10]);
    x.rsvd = v && !known;
    x.dis  = v && known && !e;
    x.wen  = v && known && e;
    x.idx  = iw[15:11];
    x.data = {hi[15:0], lo[15:0]};
    if (w) ctrl_model = wd;
    else if (x.wen && (hi[16] || lo[16])) ctrl_model[20] = 1'b1;
    x.ctrl = ctrl_model;
    x.tag  = tag;
    exp_q.push_back(x);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 32'h0, 32'h0, 32'h0, 1'b1, 1'b0, 32'h0, "R10 idle");
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_n && exp_q.size() > 0) begin
      exp_t x;
      x = exp_q.pop_front();
      checks++;
      if (wen !== x.wen || rsvd !== x.rsvd || dis !== x.dis || ctrl !== x.ctrl ||
          (x.wen && (rd_data !== x.data || rd_idx !== x.idx))) begin
        errors++;
        $display("FAIL %s: wen=%b rsvd=%b dis=%b idx=%0d data=%h ctrl=%h exp wen=%b rsvd=%b dis=%b idx=%0d data=%h ctrl=%h",
                 x.tag, wen, rsvd, dis, rd_idx, rd_data, ctrl,
                 x.wen, x.rsvd, x.dis, x.idx, x.data, x.ctrl);
      end
    end
  end

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    checks++;
    if (wen !== 0 || rsvd !== 0 || dis !== 0 || rd_data !== 0 || rd_idx !== 0 || ctrl !== 0) begin
      errors++;
      $display("FAIL R11: wen=%b rsvd=%b dis=%b data=%h ctrl=%h exp all 0", wen, rsvd, dis, rd_data, ctrl);
    end
    rst_n = 1'b1;

    // R1: read indices follow the rs/rt fields
    @(negedge clk);
    instr = enc(5'd19, 5'd6, 5'd1, 1'b0);
    #1;
    checks++;
    if (rs_idx !== 5'd6 || rt_idx !== 5'd19) begin
      errors++;
      $display("FAIL R1: rs_idx=%0d rt_idx=%0d exp 6 19", rs_idx, rt_idx);
    end

    step(1, enc(5'd2, 5'd3, 5'd4, 0), 32'h1234_0001, 32'h0001_7000, 1, 0, 0, "R2 lanes no ovf");
    step(1, enc(5'd2, 5'd3, 5'd5, 0), 32'h7FFF_0002, 32'h0001_0003, 1, 0, 0, "R3 upper wraps, R5 flag");
    step(1, enc(5'd2, 5'd3, 5'd6, 0), 32'h0000_0000, 32'h0000_0000, 1, 0, 0, "R5 flag sticky");
    idle(1);
    step(0, 0, 0, 0, 1, 1, 32'h0F0F_F0F0, "R7 write clears bit 20");
    step(1, enc(5'd1, 5'd1, 5'd7, 1), 32'h7000_8000, 32'h7000_FFFF, 1, 0, 0, "R4 clamp both ways, R6 bits kept");
    step(1, enc(5'd1, 5'd1, 5'd8, 1), 32'hFFFF_7FFF, 32'hFFFF_0000, 1, 0, 0, "R4 no-ovf sat");
    step(1, enc(5'd1, 5'd1, 5'd9, 1), 32'h0001_7FFF, 32'h7FFF_0001, 1, 1, 32'h0000_0001, "R7 write beats sticky set");
    step(1, enc(5'd1, 5'd1, 5'd10, 0), 32'h8000_0001, 32'h8000_0001, 1, 0, 0, "R3 wrap 8000+8000, R2 lower clean");
    step(0, 0, 0, 0, 1, 1, 32'h0000_0000, "R7 clear");
    step(1, 32'h2000_0408 | {6'b111000, 26'h0}, 32'h7FFF_7FFF, 32'h7FFF_7FFF, 1, 0, 0, "R8 bad major");
    step(1, enc(5'd1, 5'd1, 5'd11, 0) ^ 32'h0000_0010, 32'h7FFF_7FFF, 32'h7FFF_7FFF, 1, 0, 0, "R8 bad sub");
    step(1, enc(5'd1, 5'd1, 5'd11, 1) ^ 32'h0000_0001, 32'h8000_8000, 32'h8000_8000, 1, 0, 0, "R8 bad minor");
    step(1, enc(5'd1, 5'd1, 5'd11, 0) ^ 32'h8000_0000, 32'h7FFF_7FFF, 32'h7FFF_7FFF, 0, 0, 0, "R8 beats disabled");
    step(1, enc(5'd1, 5'd1, 5'd12, 1), 32'h7FFF_7FFF, 32'h7FFF_7FFF, 0, 0, 0, "R9 disabled");
    idle(2);
    step(1, enc(5'd1, 5'd1, 5'd13, 0), 32'h0003_0004, 32'h0005_0006, 1, 0, 0, "R10 back-to-back a");
    step(1, enc(5'd1, 5'd1, 5'd14, 1), 32'h4000_C000, 32'h4000_C000, 1, 0, 0, "R10 back-to-back b, R4");
    idle(2);

    for (int i = 0; i < 400; i++) begin
      logic w;
      seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
      r = seed;
      seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
      w = (seed[7:4] == 4'h0);
      step(seed[0] | seed[1], enc(r[4:0], r[9:5], r[14:10], seed[2]) ^ (seed[12:8] == 5'h0 ? 32'h4 : 32'h0),
           r, seed, seed[3] | seed[6], w, {r[15:0], seed[31:16]}, "R2/R3/R4/R5 random");
    end
    idle(2);
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule